// File: doc/BRIEF.md
# Four-Register Micro-Sequencer Core

A small multi-cycle processor core for housekeeping tasks next to a larger system. It runs fixed 32-bit instructions from a word-addressed memory. The same memory also holds its data. The core has four 16-bit general registers and an 11-bit program counter. It supports register and immediate arithmetic, absolute and relative branches, indirect loads and stores, a programmable stall and a halt. After reset it fetches from word 0. It runs until it reaches a halt instruction, and it stays halted until the next reset.

The memory port is a single port with a combinational read. The core drives a word address. Read data must come back within the same cycle. A write strobe commits a word at the next rising edge. Every instruction takes one fetch cycle and one execute cycle. Each store places the address of the storing instruction in the upper half of the written word, so a memory dump shows where every value came from. An end instruction with its wake bit set produces a single-cycle wake pulse. The sleep-select form of that instruction and the opcodes for peripherals and converters have no effect.

Top module: `tcore_top`

## Requirements
- R1: While reset is asserted and after it is released, halted_o and mem_we_o are low. The first fetch reads word 0.
- R2: Instruction fields are laid out as follows. The opcode is in bits 31:28: 4 delay, 6 store, 7 ALU, 8 branch, 9 end, 11 halt, 13 load. The sub-opcode is in bits 27:25. The destination register dreg is in bits 1:0 and the source register sreg is in bits 3:2. The ALU select in bits 24:21 gives 0 add, 1 subtract, 2 AND, 3 OR, 4 move, 5 shift left, 6 shift right. A shift by 16 or more yields 0.
- R3: ALU sub-opcode 0 takes operand B from register treg, bits 5:4. In that form a move copies sreg. Sub-opcode 1 takes operand B from the immediate in bits 19:4, and a move copies the immediate. The result goes to dreg.
- R4: The overflow flag is set after an add that carries out of bit 15 or a subtract that borrows. Every other ALU operation clears it. The zero flag is set when the ALU result is 0. Only ALU operations change either flag.
- R5: Branch sub-opcode 0 is absolute. The type in bits 24:22 selects 0 always, 1 if the zero flag is set, 2 if the overflow flag is set; other types never branch. The target is bits 12:2, or the low 11 bits of register dreg when bit 21 is set.
- R6: Branch sub-opcode 1 compares R0, unsigned, with the immediate in bits 15:0. Bit 16 = 0 tests less-than and bit 16 = 1 tests greater-or-equal. When the test holds, PC becomes PC + magnitude (bits 23:17), or PC - magnitude when bit 24 is 1.
- R7: A load reads the word at address (sreg + bits 20:10) mod 2048 and writes its low 16 bits into dreg.
- R8: A store writes {5'b0, PC of the store, dreg[15:0]} to address (sreg + bits 20:10) mod 2048.
- R9: A delay with count n in bits 15:0 adds n cycles to its two-cycle fetch/execute. A program made of a delay followed by a halt raises halted_o 4 + n rising edges after reset release.
- R10: A halt stops fetching. halted_o stays high, mem_addr_o stays constant and no write occurs until reset.
- R11: Opcode 9 with sub-opcode 0 and bit 0 set gives one wake_o pulse, visible after the edge that ends its execute cycle. Sub-opcode 1 (sleep select) or bit 0 clear gives no pulse.
- R12: Unknown opcodes, ALU sub-opcodes other than 0 and 1, and ALU selects above 6 change no register and no flag, and the PC simply advances.
- R13: The PC wraps modulo 2048, both when incrementing and on relative branches.
- R14: mem_we_o is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 11 | Word address for fetch or data access |
| mem_we_o | output | 1 | Write strobe for the addressed word |
| mem_wdata_o | output | 32 | Word to be written |
| mem_rdata_i | input | 32 | Combinational read data of the addressed word |
| halted_o | output | 1 | Core has halted |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The registers and flags are not visible at the ports, and so are hard to observe. Each test program therefore ends by storing its registers. It reports the flags by routing conditional branches to stores that leave a marker at a known address. The stamped PC in each stored word also shows which path ran. PC wrap-around needs control to pass the top of memory. The wrap program branches backwards past word 0, continues through the last word, and returns to word 0. Register R0 records that the first visit has already happened.

// File: rtl/tcore_pkg.sv
package tcore_pkg;
  localparam int PC_W   = 11;
  localparam int DATA_W = 16;
  localparam int INSN_W = 32;
  localparam int NREG   = 4;
  localparam int RIDX_W = $clog2(NREG);
  localparam int PAD_W  = INSN_W - PC_W - DATA_W;

  localparam logic [3:0] OP_DELAY  = 4'd4;
  localparam logic [3:0] OP_STORE  = 4'd6;
  localparam logic [3:0] OP_ALU    = 4'd7;
  localparam logic [3:0] OP_BRANCH = 4'd8;
  localparam logic [3:0] OP_END    = 4'd9;
  localparam logic [3:0] OP_HALT   = 4'd11;
  localparam logic [3:0] OP_LOAD   = 4'd13;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_MOV = 4'd4, ALU_LSH = 4'd5, ALU_RSH = 4'd6
  } alu_op_e;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_WAIT, ST_HALT} state_e;
endpackage

// File: rtl/tcore_alu.sv
module tcore_alu
  import tcore_pkg::*;
(
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o,
  output logic              valid_o
);
  logic [DATA_W:0] sum, dif;

  always_comb begin
    sum     = {1'b0, a_i} + {1'b0, b_i};
    dif     = {1'b0, a_i} - {1'b0, b_i};
    res_o   = '0;
    ovf_o   = 1'b0;
    valid_o = 1'b1;
    unique case (op_i)
      ALU_ADD: begin res_o = sum[DATA_W-1:0]; ovf_o = sum[DATA_W]; end
      ALU_SUB: begin res_o = dif[DATA_W-1:0]; ovf_o = dif[DATA_W]; end
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_MOV: res_o = b_i;
      ALU_LSH: res_o = a_i << b_i;
      ALU_RSH: res_o = a_i >> b_i;
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcore_regfile.sv
module tcore_regfile
  import tcore_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [RIDX_W-1:0]           waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_o[g] <= '0;
      else if (we_i && waddr_i == RIDX_W'(g))      regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/tcore_branch.sv
module tcore_branch
  import tcore_pkg::*;
(
  input  logic [INSN_W-1:0] ir_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] r0_i,
  input  logic [PC_W-1:0]   rd_i,
  input  logic              zf_i,
  input  logic              of_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   target_o
);
  logic [DATA_W-1:0] imm;
  logic [PC_W-1:0]   mag;
  logic              cond;

  always_comb begin
    imm      = ir_i[15:0];
    mag      = PC_W'(ir_i[23:17]);
    taken_o  = 1'b0;
    target_o = pc_i;
    cond     = ir_i[16] ? (r0_i >= imm) : (r0_i < imm);
    if (ir_i[31:28] == OP_BRANCH) begin
      unique case (ir_i[27:25])
        3'd0: begin
          target_o = ir_i[21] ? rd_i : ir_i[12:2];
          unique case (ir_i[24:22])
            3'd0:    taken_o = 1'b1;
            3'd1:    taken_o = zf_i;
            3'd2:    taken_o = of_i;
            default: taken_o = 1'b0;
          endcase
        end
        3'd1: begin
          target_o = ir_i[24] ? pc_i - mag : pc_i + mag;
          taken_o  = cond;
        end
        default: taken_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tcore_top.sv
module tcore_top
  import tcore_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [PC_W-1:0]   mem_addr_o,
  output logic              mem_we_o,
  output logic [INSN_W-1:0] mem_wdata_o,
  input  logic [INSN_W-1:0] mem_rdata_i,
  output logic              halted_o,
  output logic              wake_o
);
  state_e                      state_q;
  logic [PC_W-1:0]             pc_q;
  logic [INSN_W-1:0]           ir_q;
  logic [DATA_W-1:0]           dly_q;
  logic                        zf_q, of_q, wake_q;

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [3:0]                  op;
  logic [2:0]                  sub;
  logic [RIDX_W-1:0]           dreg, sreg, treg;
  logic [DATA_W-1:0]           rs, rt, rd, opb, alu_res, rf_wdata;
  logic                        alu_ovf, alu_valid, alu_go, rf_we, exec, is_mem;
  logic                        br_taken;
  logic [PC_W-1:0]             br_target, data_addr, pc_inc;
  alu_op_e                     alu_op;

  assign op     = ir_q[31:28];
  assign sub    = ir_q[27:25];
  assign dreg   = ir_q[1:0];
  assign sreg   = ir_q[3:2];
  assign treg   = ir_q[5:4];
  assign alu_op = alu_op_e'(ir_q[24:21]);
  assign rs     = regs[sreg];
  assign rt     = regs[treg];
  assign rd     = regs[dreg];
  assign exec   = (state_q == ST_EXEC);
  assign pc_inc = pc_q + 1'b1;

  // register-form move copies sreg; immediate-form move copies the immediate
  assign opb = sub[0] ? ir_q[19:4] : ((alu_op == ALU_MOV) ? rs : rt);

  tcore_alu i_alu (
    .op_i(alu_op), .a_i(rs), .b_i(opb),
    .res_o(alu_res), .ovf_o(alu_ovf), .valid_o(alu_valid)
  );

  tcore_branch i_branch (
    .ir_i(ir_q), .pc_i(pc_q), .r0_i(regs[0]), .rd_i(rd[PC_W-1:0]),
    .zf_i(zf_q), .of_i(of_q), .taken_o(br_taken), .target_o(br_target)
  );

  assign alu_go   = exec && op == OP_ALU && sub[2:1] == 2'b00 && alu_valid;
  assign rf_we    = alu_go || (exec && op == OP_LOAD);
  assign rf_wdata = alu_go ? alu_res : mem_rdata_i[DATA_W-1:0];

  tcore_regfile i_regfile (
    .clk_i, .rst_ni, .we_i(rf_we), .waddr_i(dreg), .wdata_i(rf_wdata), .regs_o(regs)
  );

  assign data_addr   = rs[PC_W-1:0] + ir_q[20:10];
  assign is_mem      = exec && (op == OP_LOAD || op == OP_STORE);
  assign mem_addr_o  = is_mem ? data_addr : pc_q;
  assign mem_we_o    = exec && op == OP_STORE;
  assign mem_wdata_o = {{PAD_W{1'b0}}, pc_q, rd};
  assign halted_o    = (state_q == ST_HALT);
  assign wake_o      = wake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      dly_q   <= '0;
      zf_q    <= 1'b0;
      of_q    <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= exec && op == OP_END && sub == 3'd0 && ir_q[0];
      if (alu_go) begin
        zf_q <= (alu_res == '0);
        of_q <= alu_ovf;
      end
      unique case (state_q)
        ST_FETCH: begin
          ir_q    <= mem_rdata_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op == OP_HALT) begin
            state_q <= ST_HALT;
          end else if (op == OP_DELAY) begin
            pc_q  <= pc_inc;
            dly_q <= ir_q[DATA_W-1:0];
            state_q <= (ir_q[DATA_W-1:0] != '0) ? ST_WAIT : ST_FETCH;
          end else begin
            pc_q    <= br_taken ? br_target : pc_inc;
            state_q <= ST_FETCH;
          end
        end
        ST_WAIT: begin
          dly_q <= dly_q - 1'b1;
          if (dly_q == DATA_W'(1)) state_q <= ST_FETCH;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/tcore_chk.sv
module tcore_chk
  import tcore_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PC_W-1:0]   mem_addr_o,
  input logic              mem_we_o,
  input logic [INSN_W-1:0] mem_wdata_o,
  input logic              halted_o,
  input logic              wake_o
);
  assert_store_pad_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[INSN_W-1:PC_W+DATA_W] == '0);

  // the store executes right after its own fetch, so the stamp matches the last fetch address
  assert_store_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[PC_W+DATA_W-1:DATA_W] == $past(mem_addr_o));

  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_halt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);

  assert_halt_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(mem_addr_o));

  assert_wake_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  assert_we_single_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

bind tcore_top tcore_chk i_chk (.*);

// File: tb/test_tcore_top.sv
`timescale 1ns/1ps
module test_tcore_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] mem_addr_o;
  logic        mem_we_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i;
  logic        halted_o;
  logic        wake_o;
  logic [31:0] mem [2048];
  int total = 0;
  int fails = 0;

  always #2 clk_i = ~clk_i;

  tcore_top i_tcore_top (.*);

  assign mem_rdata_i = mem[mem_addr_o];
  always @(posedge clk_i) if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;

  localparam logic [31:0] NOP = 32'hF000_0000;
  localparam logic [31:0] MARK = 32'hFFFF_FFFF;
  localparam logic [31:0] HALT = 32'hB000_0000;

  function automatic logic [31:0] f_alur(int sel, int d, int s, int t);
    return {4'd7, 3'd0, 4'(sel), 15'd0, 2'(t), 2'(s), 2'(d)};
  endfunction
  function automatic logic [31:0] f_alui(int sel, int d, int s, logic [15:0] imm);
    return {4'd7, 3'd1, 4'(sel), 1'b0, imm, 2'(s), 2'(d)};
  endfunction
  function automatic logic [31:0] f_st(int d, int s, int off);
    return {4'd6, 3'd4, 4'd0, 11'(off), 6'd0, 2'(s), 2'(d)};
  endfunction
  function automatic logic [31:0] f_ld(int d, int s, int off);
    return {4'd13, 7'd0, 11'(off), 6'd0, 2'(s), 2'(d)};
  endfunction
  function automatic logic [31:0] f_bx(int typ, int rsel, int d, int addr);
    return {4'd8, 3'd0, 3'(typ), 1'(rsel), 8'd0, 11'(addr), 2'(d)};
  endfunction
  function automatic logic [31:0] f_br(int sgn, int mag, int cmp, logic [15:0] imm);
    return {4'd8, 3'd1, 1'(sgn), 7'(mag), 1'(cmp), imm};
  endfunction
  function automatic logic [31:0] f_delay(int n);
    return {4'd4, 12'd0, 16'(n)};
  endfunction
  function automatic logic [31:0] stw(int pc, logic [15:0] v);
    return {5'd0, 11'(pc), v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = NOP;
  endtask

  task automatic run_prog(output int cyc, output int wakes, output int wake_at);
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc = 0; wakes = 0; wake_at = -1;
    while (!halted_o && cyc < 3000) begin
      @(posedge clk_i); #1;
      cyc++;
      if (wake_o) begin
        wakes++;
        if (wake_at < 0) wake_at = cyc;
      end
    end
    if (!halted_o) chk(1'b0, "R10 program did not halt", 32'(cyc), 32'd3000);
  endtask

  function automatic void alu_ref(int sel, logic [15:0] a, logic [15:0] b,
                                  output logic [15:0] r, output bit ov);
    int s;
    ov = 1'b0;
    case (sel)
      0: begin s = int'(a) + int'(b); r = 16'(s); ov = (s > 65535); end
      1: begin r = a - b; ov = (a < b); end
      2: r = a & b;
      3: r = a | b;
      4: r = b;
      5: r = (b >= 16) ? 16'd0 : 16'(a << b);
      default: r = (b >= 16) ? 16'd0 : 16'(a >> b);
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int cyc, wk, wat;
    logic [15:0] pa [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0005, 16'h8000, 16'h1234, 16'hF0F0, 16'h0007};
    logic [15:0] pb [8] = '{16'h0000, 16'h0001, 16'h0001, 16'h0009, 16'h8000, 16'h0003, 16'h0FF0, 16'h0010};
    clear_mem();
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk(!halted_o, "R1 halted in reset", 32'(halted_o), 0);
    chk(!mem_we_o, "R1 write in reset", 32'(mem_we_o), 0);
    chk(mem_addr_o == 0, "R1 fetch address", 32'(mem_addr_o), 0);

    // R2 R3 R4 R8: ALU sweep, both operand forms
    for (int form = 0; form < 2; form++) begin
      for (int sel = 0; sel < 7; sel++) begin
        for (int p = 0; p < 8; p++) begin
          logic [15:0] r;
          bit ov;
          clear_mem();
          mem[0] = f_alui(4, 1, 0, pa[p]);
          mem[1] = f_alui(4, 2, 0, pb[p]);
          mem[2] = form ? f_alui(sel, 3, 1, pb[p]) : f_alur(sel, 3, 1, 2);
          mem[3] = f_st(3, 0, 100);
          mem[4] = f_bx(1, 0, 0, 6);
          mem[5] = f_bx(0, 0, 0, 7);
          mem[6] = f_st(1, 0, 101);
          mem[7] = f_bx(2, 0, 0, 9);
          mem[8] = HALT;
          mem[9] = f_st(2, 0, 102);
          mem[10] = HALT;
          mem[100] = MARK; mem[101] = MARK; mem[102] = MARK;
          alu_ref(sel, pa[p], pb[p], r, ov);
          if (!form && sel == 4) r = pa[p];
          if (!form && sel == 4) ov = 1'b0;
          run_prog(cyc, wk, wat);
          chk(mem[100] == stw(3, r), $sformatf("R2 R3 R8 form%0d sel%0d pair%0d result", form, sel, p), mem[100], stw(3, r));
          chk(mem[101] == ((r == 0) ? stw(6, pa[p]) : MARK), $sformatf("R4 R5 zero flag sel%0d pair%0d", sel, p),
              mem[101], (r == 0) ? stw(6, pa[p]) : MARK);
          chk(mem[102] == (ov ? stw(9, pb[p]) : MARK), $sformatf("R4 R5 overflow flag sel%0d pair%0d", sel, p),
              mem[102], ov ? stw(9, pb[p]) : MARK);
        end
      end
    end

    // R6 relative branch forward, both comparisons
    for (int cmp = 0; cmp < 2; cmp++) begin
      logic [15:0] vs [5] = '{16'd0, 16'd4, 16'd5, 16'd6, 16'hFFFF};
      for (int i = 0; i < 5; i++) begin
        bit tk;
        clear_mem();
        mem[0] = f_alui(4, 0, 0, vs[i]);
        mem[1] = f_br(0, 3, cmp, 16'd5);
        mem[2] = f_st(0, 1, 110);
        mem[3] = HALT;
        mem[4] = f_st(0, 1, 111);
        mem[5] = HALT;
        mem[110] = MARK; mem[111] = MARK;
        tk = cmp ? (vs[i] >= 5) : (vs[i] < 5);
        run_prog(cyc, wk, wat);
        chk(mem[111] == (tk ? stw(4, vs[i]) : MARK), $sformatf("R6 taken cmp%0d v%0h", cmp, vs[i]), mem[111], tk ? stw(4, vs[i]) : MARK);
        chk(mem[110] == (tk ? MARK : stw(2, vs[i])), $sformatf("R6 fallthrough cmp%0d v%0h", cmp, vs[i]), mem[110], tk ? MARK : stw(2, vs[i]));
      end
    end

    // R6 backward relative branch
    clear_mem();
    mem[0] = f_bx(0, 0, 0, 10);
    mem[8] = f_st(0, 1, 112);
    mem[9] = HALT;
    mem[10] = f_alui(4, 0, 0, 16'd3);
    mem[11] = f_br(1, 3, 0, 16'd5);
    mem[12] = HALT;
    mem[112] = MARK;
    run_prog(cyc, wk, wat);
    chk(mem[112] == stw(8, 16'd3), "R6 backward offset", mem[112], stw(8, 16'd3));

    // R5 register target uses the low 11 bits
    clear_mem();
    mem[0] = f_alui(4, 1, 0, 16'hF805);
    mem[1] = f_bx(0, 1, 1, 0);
    mem[2] = f_st(1, 0, 150);
    mem[3] = HALT;
    mem[5] = f_st(1, 0, 151);
    mem[6] = HALT;
    mem[150] = MARK; mem[151] = MARK;
    run_prog(cyc, wk, wat);
    chk(mem[151] == stw(5, 16'hF805), "R5 register target", mem[151], stw(5, 16'hF805));
    chk(mem[150] == MARK, "R5 register target fallthrough", mem[150], MARK);

    // R7 load
    clear_mem();
    mem[0] = f_alui(4, 1, 0, 16'd190);
    mem[1] = f_ld(2, 1, 10);
    mem[2] = f_st(2, 0, 120);
    mem[3] = HALT;
    mem[200] = 32'hABCD_1234;
    run_prog(cyc, wk, wat);
    chk(mem[120] == stw(2, 16'h1234), "R7 load low half", mem[120], stw(2, 16'h1234));

    // R12 unknown opcodes and invalid ALU forms leave R1 untouched
    clear_mem();
    mem[0] = f_alui(4, 1, 0, 16'd7);
    mem[1] = 32'hE000_0003;
    mem[2] = 32'h5000_0001;
    mem[3] = 32'h7400_0FF1;
    mem[4] = 32'h70E0_0001;
    mem[5] = f_st(1, 0, 130);
    mem[6] = HALT;
    run_prog(cyc, wk, wat);
    chk(mem[130] == stw(5, 16'd7), "R12 no-op opcodes", mem[130], stw(5, 16'd7));

    // R13 PC wrap on relative branch and increment
    clear_mem();
    mem[0] = f_br(0, 3, 1, 16'd1);
    mem[1] = f_alui(4, 0, 0, 16'd1);
    mem[2] = f_br(1, 5, 1, 16'd0);
    mem[2045] = f_bx(0, 0, 0, 2047);
    mem[2047] = f_delay(0);
    mem[3] = f_st(0, 1, 142);
    mem[4] = HALT;
    mem[142] = MARK;
    run_prog(cyc, wk, wat);
    chk(mem[142] == stw(3, 16'd1), "R13 pc wrap", mem[142], stw(3, 16'd1));

    // R9 delay timing, R10 halt quiet
    begin
      int ns [5] = '{0, 1, 2, 5, 37};
      for (int i = 0; i < 5; i++) begin
        clear_mem();
        mem[0] = f_delay(ns[i]);
        mem[1] = HALT;
        run_prog(cyc, wk, wat);
        chk(cyc == 4 + ns[i], $sformatf("R9 delay %0d", ns[i]), 32'(cyc), 32'(4 + ns[i]));
      end
      for (int k = 0; k < 10; k++) begin
        @(posedge clk_i); #1;
        chk(halted_o && !mem_we_o && mem_addr_o == 1, "R10 halted quiet",
            {20'd0, halted_o, mem_we_o, mem_addr_o}, {20'd0, 1'b1, 1'b0, 11'd1});
      end
    end

    // R11 wake pulse
    clear_mem();
    mem[0] = {4'd9, 3'd0, 24'd0, 1'b1};
    mem[1] = {4'd9, 3'd1, 25'd3};
    mem[2] = {4'd9, 3'd0, 25'd0};
    mem[3] = HALT;
    run_prog(cyc, wk, wat);
    chk(wk == 1, "R11 wake count", 32'(wk), 1);
    chk(wat == 2, "R11 wake timing", 32'(wat), 2);
    clear_mem();
    mem[0] = {4'd9, 3'd1, 25'd1};
    mem[1] = {4'd9, 3'd0, 25'd0};
    mem[2] = HALT;
    run_prog(cyc, wk, wat);
    chk(wk == 0, "R11 sleep select no wake", 32'(wk), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule